// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches the eight input lines of one GPIO port and raises a single interrupt request when any enabled line meets its trigger condition. Software sets each line up through byte-wide registers on a simple memory-mapped bus. Bit n of every register belongs to line n.

Each line has two type bits. The first selects level or edge sensing. The second selects the active level or edge direction. A line can also pass its input through a debounce filter before detection. Detected edges are held in a per-line latch until software acknowledges them. Software can read a raw status, which ignores the enables, and a masked status. The interrupt output is the OR of the masked bits.

Every pin is first brought into the clock domain by a two-stage synchroniser. A line that software reprograms is never given a spurious event, so software can obtain both edges by flipping the polarity bit after each acknowledge.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the registers at 0x00, 0x04, 0x0C and 0x18 read 0. Raw status (0x14) and masked status (0x10) read 0 while all pins are high, and irqOut is 0.
- R2: The mode (0x00), polarity (0x04), enable (0x0C) and debounce (0x18) registers read back the last byte written to them. Bit n of each register controls line n.
- R3: When a line's mode bit is 0, its raw status bit is 1 exactly while the input is at the selected level. Polarity 1 selects high and polarity 0 selects low. An acknowledge has no effect on a line in level mode.
- R4: When a line's mode bit is 1, its raw status bit sets on the selected edge and stays set after the input returns. Polarity 1 selects rising and polarity 0 selects falling. The opposite edge sets nothing.
- R5: Writing a byte to the acknowledge register (0x08) clears the held edge of every line whose bit is 1. Lines whose bit is 0 keep their state. Reading 0x08 returns 0.
- R6: Masked status (0x10) equals raw status ANDed with the enable register. irqOut is 1 exactly when masked status is nonzero.
- R7: Writing the mode or polarity register creates no event on any line whose input is steady. Any line whose bit changes loses its held edge.
- R8: When a line's debounce bit is 1, an input change shorter than DB_CYCLES clocks (default 4) is ignored. A change that is held longer is accepted. With the bit at 0, the same short pulse is detected.
- R9: If an acknowledge and a new selected edge reach a line in the same cycle, the edge wins and the raw status bit stays 1.
- R10: Pin inputs are synchronised before use, so a pin change is not visible in status during the first clock after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (5) | Byte offset of the register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational, 0 when not reading) |
| pinIn | input | 8 | Asynchronous pin levels |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: an acknowledge write and the arrival of a fresh selected edge on the same line. The bench provokes this by lowering a pin one clock before it drives the acknowledge write. The synchronised edge then reaches the latch on the very edge at which the write is taken. The bench judges the result by reading raw status, which must still show the line set. A plain acknowledge with no competing edge must clear the line. A second collision happens when a type register is written while a line holds an edge. The bench checks that this write discards the held edge and does not create a new one.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int NUM_LINES = 8;

  // Register byte offsets
  localparam int OFF_MODE   = 'h00;
  localparam int OFF_POL    = 'h04;
  localparam int OFF_ACK    = 'h08;
  localparam int OFF_ENABLE = 'h0C;
  localparam int OFF_MASKED = 'h10;
  localparam int OFF_RAW    = 'h14;
  localparam int OFF_DEBNC  = 'h18;

  typedef logic [NUM_LINES-1:0] lineVec_t;

  // Strobes from register control to the line datapath
  typedef struct packed {
    lineVec_t ackMask;    // clear held edges (edge wins over this)
    lineVec_t flushMask;  // type change: discard held edges (wins over edge)
  } lineStrobe_t;

endpackage

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = $clog2(STABLE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE - 1);

  logic [CNT_W-1:0] runCnt;
  logic             level;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      level  <= 1'b0;
    end else if (din == level) begin
      runCnt <= '0;
    end else if (runCnt == LAST) begin
      runCnt <= '0;
      level  <= din;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign dout = level;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  lineVec_t          busWdata,
  output lineVec_t          busRdata,
  input  lineVec_t          rawStat,
  input  lineVec_t          maskedStat,
  output lineVec_t          trigMode,
  output lineVec_t          trigPol,
  output lineVec_t          lineEn,
  output lineVec_t          dbEn,
  output lineStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFF_POL);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_DEBNC  = ADDR_W'(OFF_DEBNC);

  logic wrHit, rdHit;
  assign wrHit = busSel & busWe;
  assign rdHit = busSel & ~busWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigMode <= '0;
      trigPol  <= '0;
      lineEn   <= '0;
      dbEn     <= '0;
    end else if (wrHit) begin
      case (busAddr)
        A_MODE:   trigMode <= busWdata;
        A_POL:    trigPol  <= busWdata;
        A_ENABLE: lineEn   <= busWdata;
        A_DEBNC:  dbEn     <= busWdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (wrHit) begin
      if (busAddr == A_ACK)  strobe.ackMask   = busWdata;
      if (busAddr == A_MODE) strobe.flushMask = busWdata ^ trigMode;
      if (busAddr == A_POL)  strobe.flushMask = busWdata ^ trigPol;
    end
  end

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      case (busAddr)
        A_MODE:   busRdata = trigMode;
        A_POL:    busRdata = trigPol;
        A_ENABLE: busRdata = lineEn;
        A_MASKED: busRdata = maskedStat;
        A_RAW:    busRdata = rawStat;
        A_DEBNC:  busRdata = dbEn;
        default:  busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_lines.sv
module gpio_irq_lines
  import gpio_irq_pkg::*;
#(
  parameter int DB_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  lineVec_t    pinIn,
  input  lineVec_t    trigMode,
  input  lineVec_t    trigPol,
  input  lineVec_t    lineEn,
  input  lineVec_t    dbEn,
  input  lineStrobe_t strobe,
  output lineVec_t    rawStat,
  output lineVec_t    maskedStat,
  output logic        irqOut
);
  lineVec_t syncA, syncB, filtered, selIn, prevIn, edgeLatch, setEv, levelHit;

  // Two-stage synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gpio_irq_filter #(.STABLE(DB_CYCLES)) u_filter (
      .clk (clk),
      .rstN(rstN),
      .din (syncB[i]),
      .dout(filtered[i])
    );
  end

  assign selIn    = (dbEn & filtered) | (~dbEn & syncB);
  assign setEv    = trigMode & ((trigPol & selIn & ~prevIn) |
                                (~trigPol & ~selIn & prevIn));
  assign levelHit = ~(selIn ^ trigPol);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn    <= '0;
      edgeLatch <= '0;
    end else begin
      prevIn    <= selIn;
      edgeLatch <= ((edgeLatch & ~strobe.ackMask) | setEv) & ~strobe.flushMask;
    end
  end

  assign rawStat    = (trigMode & edgeLatch) | (~trigMode & levelHit);
  assign maskedStat = rawStat & lineEn;
  assign irqOut     = |maskedStat;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [7:0]        pinIn,
  output logic              irqOut
);
  lineVec_t    trigMode, trigPol, lineEn, dbEn, rawStat, maskedStat;
  lineStrobe_t strobe;

  gpio_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .rawStat   (rawStat),
    .maskedStat(maskedStat),
    .trigMode  (trigMode),
    .trigPol   (trigPol),
    .lineEn    (lineEn),
    .dbEn      (dbEn),
    .strobe    (strobe)
  );

  gpio_irq_lines #(.DB_CYCLES(DB_CYCLES)) u_lines (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .trigMode  (trigMode),
    .trigPol   (trigPol),
    .lineEn    (lineEn),
    .dbEn      (dbEn),
    .strobe    (strobe),
    .rawStat   (rawStat),
    .maskedStat(maskedStat),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              irqOut,
  input lineVec_t          trigMode,
  input lineVec_t          trigPol,
  input lineVec_t          lineEn,
  input lineVec_t          rawStat,
  input lineVec_t          maskedStat
);
  logic wrMode, wrPol;
  assign wrMode = busSel & busWe & (busAddr == ADDR_W'(OFF_MODE));
  assign wrPol  = busSel & busWe & (busAddr == ADDR_W'(OFF_POL));

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && busAddr == ADDR_W'(OFF_ACK)) |-> busRdata == 8'h00); // R5

  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStat & ~(rawStat & lineEn)) == '0); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> lineEn != '0); // R6

  AST_MODE_WRITE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    wrMode |=> (rawStat & trigMode & $past(busWdata ^ trigMode)) == '0); // R7

  AST_POL_WRITE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    wrPol |=> (rawStat & trigMode & $past(busWdata ^ trigPol)) == '0); // R7
endmodule

bind gpio_irq_unit gpio_irq_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .irqOut    (irqOut),
  .trigMode  (trigMode),
  .trigPol   (trigPol),
  .lineEn    (lineEn),
  .rawStat   (rawStat),
  .maskedStat(maskedStat)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_MODE = 5'h00, A_POL = 5'h04, A_ACK = 5'h08,
                                A_EN = 5'h0C, A_MASK = 5'h10, A_RAW = 5'h14, A_DB = 5'h18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata, pinIn = 8'hFF;
  logic irqOut;
  logic irqProbe = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_unit #(.ADDR_W(ADDR_W), .DB_CYCLES(4)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .irqOut(irqOut)
  );

  typedef struct {
    bit         isIrq;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Monitor: pops expected items as results appear on the ports
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (irqProbe || (busSel && !busWe)) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL monitor: result with no expected item");
        end else begin
          item_t it;
          logic [7:0] act;
          it = expQ.pop_front();
          act = it.isIrq ? {7'b0, irqOut} : busRdata;
          checks++;
          if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
          end
        end
      end
    end
  end

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic expectReg(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string req);
    item_t it;
    @(negedge clk);
    it.isIrq = 1'b0; it.exp = e; it.req = req;
    expQ.push_back(it);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic expectIrq(input logic e, input string req);
    item_t it;
    @(negedge clk);
    it.isIrq = 1'b1; it.exp = {7'b0, e}; it.req = req;
    expQ.push_back(it);
    irqProbe = 1'b1;
    @(negedge clk);
    irqProbe = 1'b0;
  endtask

  task automatic setPins(input logic [7:0] v, input int settle);
    @(negedge clk);
    pinIn = v;
    repeat (settle) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expectReg(A_MODE, 8'h00, "R1 mode");
    expectReg(A_POL,  8'h00, "R1 pol");
    expectReg(A_EN,   8'h00, "R1 enable");
    expectReg(A_DB,   8'h00, "R1 debounce");
    expectReg(A_RAW,  8'h00, "R1 raw");
    expectReg(A_MASK, 8'h00, "R1 masked");
    expectIrq(1'b0, "R1 irq");

    // R2 read-back
    busWrite(A_MODE, 8'h5A); expectReg(A_MODE, 8'h5A, "R2 mode");
    busWrite(A_MODE, 8'h00);
    busWrite(A_POL, 8'h81);  expectReg(A_POL, 8'h81, "R2 pol");
    busWrite(A_POL, 8'h00);
    busWrite(A_EN, 8'h3C);   expectReg(A_EN, 8'h3C, "R2 enable");
    busWrite(A_EN, 8'h00);
    busWrite(A_DB, 8'hC3);   expectReg(A_DB, 8'hC3, "R2 debounce");
    busWrite(A_DB, 8'h00);

    // R5 ack register reads zero
    busWrite(A_ACK, 8'hFF);
    expectReg(A_ACK, 8'h00, "R5 ack reads 0");

    // R3 level high on line 0
    busWrite(A_POL, 8'h01);
    busWrite(A_EN, 8'h01);
    expectReg(A_RAW, 8'h01, "R3 level high raw");
    expectReg(A_MASK, 8'h01, "R6 masked");
    expectIrq(1'b1, "R6 irq");
    busWrite(A_ACK, 8'h01);
    expectReg(A_RAW, 8'h01, "R3 ack ignored in level mode");
    // R10: not visible in the first clock after the change
    setPins(8'hFE, 0);
    expectReg(A_RAW, 8'h01, "R10 sync delay");
    expectReg(A_RAW, 8'h00, "R3 level released");
    expectIrq(1'b0, "R6 irq low");

    // R3 level low on line 1, R6 masking
    setPins(8'hFC, 4);
    expectReg(A_RAW, 8'h02, "R3 level low raw");
    expectReg(A_MASK, 8'h00, "R6 disabled line masked");
    expectIrq(1'b0, "R6 irq masked");
    busWrite(A_EN, 8'h03);
    expectReg(A_MASK, 8'h02, "R6 enabled line");
    expectIrq(1'b1, "R6 irq enabled");
    busWrite(A_EN, 8'h00);
    setPins(8'hFF, 4);
    busWrite(A_POL, 8'h00);

    // R4 rising edge on line 2
    busWrite(A_POL, 8'h04);
    busWrite(A_MODE, 8'h04);
    busWrite(A_EN, 8'h04);
    setPins(8'hFB, 4);
    expectReg(A_RAW, 8'h00, "R4 falling ignored in rising mode");
    setPins(8'hFF, 4);
    expectReg(A_RAW, 8'h04, "R4 rising latched");
    expectIrq(1'b1, "R6 irq edge");
    setPins(8'hFB, 4);
    expectReg(A_RAW, 8'h04, "R4 latch held");
    busWrite(A_ACK, 8'hFB);
    expectReg(A_RAW, 8'h04, "R5 zero bits no effect");
    busWrite(A_ACK, 8'h04);
    expectReg(A_RAW, 8'h00, "R5 ack clears");
    expectIrq(1'b0, "R5 irq cleared");

    // R4 falling edge on line 3
    busWrite(A_MODE, 8'h0C);
    busWrite(A_EN, 8'h08);
    setPins(8'hF3, 4);
    expectReg(A_RAW, 8'h08, "R4 falling latched");
    busWrite(A_ACK, 8'h08);
    setPins(8'hFB, 4);
    expectReg(A_RAW, 8'h00, "R4 rising ignored in falling mode");

    // R7 type change
    busWrite(A_POL, 8'h0C);
    repeat (4) @(negedge clk);
    expectReg(A_RAW, 8'h00, "R7 polarity change no event");
    setPins(8'hF3, 4);
    setPins(8'hFB, 4);
    expectReg(A_RAW, 8'h08, "R7 latch before change");
    busWrite(A_POL, 8'h04);
    expectReg(A_RAW, 8'h00, "R7 change discards latch");

    // R9 ack and new edge in the same cycle (line 3 falling mode)
    setPins(8'hF3, 4);
    expectReg(A_RAW, 8'h08, "R9 first edge");
    setPins(8'hFB, 4);
    @(negedge clk); pinIn = 8'hF3;
    @(negedge clk);
    busWrite(A_ACK, 8'h08);
    expectReg(A_RAW, 8'h08, "R9 edge wins over ack");
    busWrite(A_ACK, 8'h08);
    expectReg(A_RAW, 8'h00, "R9 plain ack clears");

    // R8 debounce on line 5 (rising)
    busWrite(A_POL, 8'h24);
    busWrite(A_MODE, 8'h2C);
    busWrite(A_DB, 8'h20);
    busWrite(A_EN, 8'h20);
    setPins(8'hD3, 10);
    busWrite(A_ACK, 8'hFF);
    expectReg(A_RAW, 8'h00, "R8 setup");
    @(negedge clk); pinIn = 8'hF3;
    repeat (3) @(negedge clk); pinIn = 8'hD3;
    repeat (10) @(negedge clk);
    expectReg(A_RAW, 8'h00, "R8 short pulse filtered");
    @(negedge clk); pinIn = 8'hF3;
    repeat (6) @(negedge clk); pinIn = 8'hD3;
    repeat (10) @(negedge clk);
    expectReg(A_RAW, 8'h20, "R8 long pulse accepted");
    busWrite(A_DB, 8'h00);
    busWrite(A_ACK, 8'h20);
    expectReg(A_RAW, 8'h00, "R8 cleared");
    @(negedge clk); pinIn = 8'hF3;
    repeat (3) @(negedge clk); pinIn = 8'hD3;
    repeat (6) @(negedge clk);
    expectReg(A_RAW, 8'h20, "R8 short pulse passes unfiltered");

    repeat (4) @(negedge clk);
    done = 1;
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL monitor: %0d expected items left unchecked", expQ.size());
    end
    finishRun();
  end
endmodule